// File: doc/BRIEF.md
# SDRAM Burst Sequencer with Early Termination

This block sits on the controller side of an SDRAM interface and turns single user requests into READ or WRITE bursts on the command pins, with the option of cutting any burst short through a Burst Stop command. The bank is assumed to be open already; row activation, precharge, mode programming and pad timing are handled elsewhere.

For reads, every beat the sequencer asks for puts a token into a delay line whose length follows the selected CAS latency (2 or 3 cycles). Data captured from the DQ bus is forwarded to the user only where a token arrives. A Burst Stop removes the tokens of the beats that were never asked for, so data keeps arriving for CAS-latency cycles after the stop and then ends. For writes, the sequencer takes a user data word in each beat cycle and drives it with the output enable high. It releases the bus in the cycle that carries the Burst Stop.

A new request is taken only while `req_ready` is high. Between commands the pins carry either Device Deselect or NOP, depending on a parameter.

Top module: `sdr_burst_seq`

## Requirements
- R1: After a synchronous active-high reset, the pins carry Deselect (all four command pins high), `dq_oe` and `rd_valid` are low and `req_ready` is high.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. In the next cycle the pins carry READ (cs_n,ras_n,cas_n,we_n = 0,1,0,1) or WRITE (0,1,0,0), and `cmd_addr` equals the accepted `req_addr`.
- R3: With the default `IDLE_DESELECT` = 1, every cycle that carries no READ, WRITE or Burst Stop shows cs_n high, so NOP (0,1,1,1) never appears.
- R4: A read that is not stopped delivers exactly `burst_len` words on `rd_data` with `rd_valid` high, in consecutive cycles and in device order. The first word appears CL+1 clock edges after the accepting edge.
- R5: `cas_lat_3` = 1 selects a CAS latency of 3 and `cas_lat_3` = 0 selects a CAS latency of 2. Both the capture point and the R4 timing follow this choice.
- R6: If `stop_req` is high at the k-th edge after the accepting edge, with 1 <= k < `burst_len`, the pins carry Burst Stop (0,1,1,0) in the following cycle. A read then delivers exactly k words.
- R7: A write drives `dq_oe` high for exactly `burst_len` consecutive cycles, beginning with the WRITE cycle. If stopped as in R6, it drives exactly k cycles, and `dq_oe` is low in the Burst Stop cycle and afterwards.
- R8: A `stop_req` that arrives when no further beat remains to be issued (k >= `burst_len`, or while idle) is ignored. No Burst Stop is sent and the beat count is unchanged.
- R9: `req_ready` stays low while a burst is being issued or read tokens are still in flight. A `req_valid` seen while `req_ready` is low produces no command.
- R10: `wr_take` is high at each edge where `wr_data` is latched for a write beat. The words then appear on `dq_out` in the order they were taken.
- R11: `burst_len` sets the number of beats, from 1 up to 2^BL_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cas_lat_3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| burst_len | input | BL_W | Beats per burst |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Column address for the burst |
| req_ready | output | 1 | Sequencer can take a request |
| stop_req | input | 1 | Cut the running burst short |
| wr_data | input | DQ_W | Write word for the next beat |
| wr_take | output | 1 | wr_data is latched at this edge |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_addr | output | ADDR_W | Address pins |
| dq_out | output | DQ_W | Write data to the DQ pads |
| dq_oe | output | 1 | DQ output enable |
| dq_in | input | DQ_W | Read data from the DQ pads |
| rd_data | output | DQ_W | Captured read word |
| rd_valid | output | 1 | rd_data holds a valid beat |

## Verification
The assertions assume that `cas_lat_3` does not change while read tokens are in flight. They also assume that `dq_in` carries device data in the cycles the latency implies. The bench changes the latency only after `req_ready` has returned high, and it drives `dq_in` from its own device model, which counts beats from the command pins alone. `stop_req` is treated as a one-cycle strobe. The bench pulses it at a single chosen edge per burst, including edges past the natural end of the burst, for CL 2 and CL 3.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam int CL_MAX = 3;

    localparam cmd_pins_t PINS_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_READ  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_pins_t PINS_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
    localparam cmd_pins_t PINS_STOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    function automatic cmd_pins_t encode_cmd(sdr_cmd_e cmd, cmd_pins_t filler);
        cmd_pins_t p;
        case (cmd)
            CMD_READ:  p = PINS_READ;
            CMD_WRITE: p = PINS_WRITE;
            CMD_STOP:  p = PINS_STOP;
            default:   p = filler;
        endcase
        return p;
    endfunction

    function automatic int unsigned latency_tap(logic cl3);
        return cl3 ? 2 : 1;
    endfunction

endpackage

// File: rtl/sdr_cmd_encode.sv
module sdr_cmd_encode
    import sdr_burst_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter bit IDLE_DESELECT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  sdr_cmd_e          cmd,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr_out
);
    cmd_pins_t filler;
    cmd_pins_t pins;

    generate
        if (IDLE_DESELECT) begin : g_desel
            assign filler = PINS_DESEL;
        end else begin : g_nop
            assign filler = PINS_NOP;
        end
    endgenerate

    always_comb begin
        pins = encode_cmd(cmd, filler);
    end

    assign cs_n     = pins.cs_n;
    assign ras_n    = pins.ras_n;
    assign cas_n    = pins.cas_n;
    assign we_n     = pins.we_n;
    assign addr_out = addr_in;

    // R3: fill cycles use deselect when configured that way
    generate
        if (IDLE_DESELECT) begin : g_chk
            a_r3_fill_is_deselect: assert property (@(posedge clk) disable iff (rst)
                (cmd == CMD_IDLE) |-> cs_n);
        end
    endgenerate

endmodule

// File: rtl/sdr_rd_valid_pipe.sv
module sdr_rd_valid_pipe
    import sdr_burst_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cas_lat_3,
    input  logic            tok_in,
    input  logic [DQ_W-1:0] dq_in,
    output logic [DQ_W-1:0] rd_data,
    output logic            rd_valid,
    output logic            empty
);
    logic [CL_MAX-1:0] tok_sr;
    logic              beat_on_bus;

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_sr <= '0;
        end else begin
            tok_sr <= {tok_sr[CL_MAX-2:0], tok_in};
        end
    end

    always_comb begin
        beat_on_bus = tok_sr[latency_tap(cas_lat_3)];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= beat_on_bus;
            if (beat_on_bus) begin
                rd_data <= dq_in;
            end
        end
    end

    assign empty = (tok_sr == '0);

    // R4, R5: a forwarded word traces back to a requested beat CL+1 edges before
    a_r4_valid_follows_token: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (cas_lat_3 ? $past(tok_in, 4) : $past(tok_in, 3)));

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
    import sdr_burst_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DQ_W   = 16,
    parameter int BL_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BL_W-1:0]   burst_len,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              stop_req,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic              pipe_empty,
    output logic              req_ready,
    output logic              wr_take,
    output sdr_cmd_e          cmd,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_tok,
    output logic              dq_oe,
    output logic [DQ_W-1:0]   dq_out
);
    seq_state_e      state;
    logic [BL_W-1:0] beats_left;
    logic            accept;
    logic            in_burst;

    assign req_ready = (state == ST_IDLE) && !rd_tok && pipe_empty;
    assign accept    = req_valid && req_ready;
    assign in_burst  = (state != ST_IDLE);
    assign wr_take   = (accept && req_write) || ((state == ST_WR) && !stop_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            beats_left <= '0;
            cmd        <= CMD_IDLE;
            cmd_addr   <= '0;
            rd_tok     <= 1'b0;
            dq_oe      <= 1'b0;
            dq_out     <= '0;
        end else begin
            cmd      <= CMD_IDLE;
            cmd_addr <= '0;
            rd_tok   <= 1'b0;
            dq_oe    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd      <= req_write ? CMD_WRITE : CMD_READ;
                        cmd_addr <= req_addr;
                        if (req_write) begin
                            dq_oe  <= 1'b1;
                            dq_out <= wr_data;
                        end else begin
                            rd_tok <= 1'b1;
                        end
                        if (burst_len > BL_W'(1)) begin
                            beats_left <= burst_len - BL_W'(1);
                            state      <= req_write ? ST_WR : ST_RD;
                        end
                    end
                end
                default: begin
                    if (stop_req) begin
                        cmd        <= CMD_STOP;
                        beats_left <= '0;
                        state      <= ST_IDLE;
                    end else begin
                        if (state == ST_WR) begin
                            dq_oe  <= 1'b1;
                            dq_out <= wr_data;
                        end else begin
                            rd_tok <= 1'b1;
                        end
                        beats_left <= beats_left - BL_W'(1);
                        if (beats_left == BL_W'(1)) begin
                            state <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // R7: the bus is released in the stop cycle
    a_r7_no_drive_on_stop: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STOP) |-> !dq_oe);

    // R8: a stop while no burst is running makes no stop command
    a_r8_late_stop_ignored: assert property (@(posedge clk) disable iff (rst)
        (!in_burst && stop_req) |=> (cmd != CMD_STOP));

    // R6: a stop command only ever follows a running burst
    a_r6_stop_inside_burst: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STOP) |-> $past(in_burst && stop_req));

    // R9: a read or write command needs a request taken while ready
    a_r9_cmd_needs_accept: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_READ) || (cmd == CMD_WRITE)) |-> $past(req_valid && req_ready));

    // R10: every driven write beat was latched one edge earlier
    a_r10_drive_after_take: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> $past(wr_take));

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DQ_W          = 16,
    parameter int BL_W          = 4,
    parameter bit IDLE_DESELECT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cas_lat_3,
    input  logic [BL_W-1:0]   burst_len,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              stop_req,
    input  logic [DQ_W-1:0]   wr_data,
    output logic              wr_take,
    output logic              cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   rd_data,
    output logic              rd_valid
);
    sdr_cmd_e          cmd;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_tok;
    logic              pipe_empty;

    sdr_burst_ctrl #(
        .ADDR_W (ADDR_W),
        .DQ_W   (DQ_W),
        .BL_W   (BL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .burst_len  (burst_len),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .stop_req   (stop_req),
        .wr_data    (wr_data),
        .pipe_empty (pipe_empty),
        .req_ready  (req_ready),
        .wr_take    (wr_take),
        .cmd        (cmd),
        .cmd_addr   (addr_q),
        .rd_tok     (rd_tok),
        .dq_oe      (dq_oe),
        .dq_out     (dq_out)
    );

    sdr_cmd_encode #(
        .ADDR_W        (ADDR_W),
        .IDLE_DESELECT (IDLE_DESELECT)
    ) u_enc (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .addr_in  (addr_q),
        .cs_n     (cmd_cs_n),
        .ras_n    (cmd_ras_n),
        .cas_n    (cmd_cas_n),
        .we_n     (cmd_we_n),
        .addr_out (cmd_addr)
    );

    sdr_rd_valid_pipe #(
        .DQ_W (DQ_W)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .cas_lat_3 (cas_lat_3),
        .tok_in    (rd_tok),
        .dq_in     (dq_in),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .empty     (pipe_empty)
    );

    // R2: a column command on the pins is never issued with the bus turned the wrong way
    a_r2_read_not_driving: assert property (@(posedge clk) disable iff (rst)
        (!cmd_cs_n && cmd_ras_n && !cmd_cas_n && cmd_we_n) |-> !dq_oe);

endmodule

// File: tb/sdr_burst_seq_test.sv
module sdr_burst_seq_test;
    localparam int ADDR_W = 13;
    localparam int DQ_W   = 16;
    localparam int BL_W   = 4;
    localparam logic [DQ_W-1:0] WBASE = 16'h4000;
    localparam logic [DQ_W-1:0] RBASE = 16'h8000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cas_lat_3 = 1'b0;
    logic [BL_W-1:0]   burst_len = 4'd4;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              stop_req = 1'b0;
    logic [DQ_W-1:0]   wr_data;
    logic              wr_take;
    logic              cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DQ_W-1:0]   dq_out;
    logic              dq_oe;
    logic [DQ_W-1:0]   dq_in = '0;
    logic [DQ_W-1:0]   rd_data;
    logic              rd_valid;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    int cyc = 0;
    int take_cnt = 0;
    int wr_seen = 0, rd_seen = 0;
    int wr_mis = 0, rd_mis = 0;
    int bst_cnt = 0, nop_cnt = 0;
    int rise_cyc = 0;
    logic rd_prev = 1'b0;
    int dev_bl = 4;
    int dev_left = 0;
    int dev_idx = 0;
    logic            slot_v [0:3];
    logic [DQ_W-1:0] slot_d [0:3];
    logic [ADDR_W-1:0] addr_seed = 13'h0105;

    always #10 clk = ~clk;

    sdr_burst_seq #(
        .ADDR_W (ADDR_W), .DQ_W (DQ_W), .BL_W (BL_W), .IDLE_DESELECT (1'b1)
    ) uut (
        .clk (clk), .rst (rst), .cas_lat_3 (cas_lat_3), .burst_len (burst_len),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_ready (req_ready), .stop_req (stop_req), .wr_data (wr_data),
        .wr_take (wr_take), .cmd_cs_n (cmd_cs_n), .cmd_ras_n (cmd_ras_n),
        .cmd_cas_n (cmd_cas_n), .cmd_we_n (cmd_we_n), .cmd_addr (cmd_addr),
        .dq_out (dq_out), .dq_oe (dq_oe), .dq_in (dq_in), .rd_data (rd_data),
        .rd_valid (rd_valid)
    );

    assign wr_data = WBASE + DQ_W'(take_cnt);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && wr_take) take_cnt <= take_cnt + 1;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            slot_v[i] = 1'b0;
            slot_d[i] = '0;
        end
    end

    // device model and output monitor, both away from the active edge
    always @(negedge clk) begin
        logic [3:0] pins;
        logic beat;
        pins = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
        for (int i = 0; i < 3; i++) begin
            slot_v[i] = slot_v[i+1];
            slot_d[i] = slot_d[i+1];
        end
        slot_v[3] = 1'b0;
        beat = 1'b0;
        if (!rst) begin
            if (pins == 4'b0101) begin
                beat = 1'b1;
                dev_left = dev_bl - 1;
            end else if (pins == 4'b0110 || pins == 4'b0100) begin
                dev_left = 0;
            end else if (dev_left > 0) begin
                beat = 1'b1;
                dev_left = dev_left - 1;
            end
            if (beat) begin
                slot_v[cas_lat_3 ? 3 : 2] = 1'b1;
                slot_d[cas_lat_3 ? 3 : 2] = RBASE + DQ_W'(dev_idx);
                dev_idx = dev_idx + 1;
            end
            if (pins == 4'b0110) bst_cnt = bst_cnt + 1;
            if (pins == 4'b0111) nop_cnt = nop_cnt + 1;
            if (dq_oe) begin
                if (dq_out != WBASE + DQ_W'(wr_seen)) wr_mis = wr_mis + 1;
                wr_seen = wr_seen + 1;
            end
            if (rd_valid) begin
                if (rd_data != RBASE + DQ_W'(rd_seen)) rd_mis = rd_mis + 1;
                rd_seen = rd_seen + 1;
                if (!rd_prev) rise_cyc = cyc;
            end
            rd_prev = rd_valid;
        end
        dq_in = slot_v[0] ? slot_d[0] : 16'hBAD0;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_reset();
        @(negedge clk);
        check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b1111, "R1 pins deselect",
              int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), 15);
        check(dq_oe == 1'b0, "R1 dq_oe low", int'(dq_oe), 0);
        check(rd_valid == 1'b0, "R1 rd_valid low", int'(rd_valid), 0);
        check(req_ready == 1'b1, "R1 ready high", int'(req_ready), 1);
    endtask

    // one burst: wr selects write, stop_at is the edge index for stop_req (0 = none)
    task automatic run_burst(input bit wr, input bit cl3, input int bl, input int stop_at);
        int s_rd, s_wr, s_bst, s_take, s_rmis, s_wmis, s_nop, acc, exp_beats, exp_bst;
        logic [3:0] exp_pins;
        logic [ADDR_W-1:0] a;
        @(negedge clk); #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        a = addr_seed;
        addr_seed = addr_seed + 13'h0011;
        cas_lat_3 = cl3;
        burst_len = BL_W'(bl);
        dev_bl    = bl;
        req_write = wr;
        req_addr  = a;
        req_valid = 1'b1;
        s_rd = rd_seen; s_wr = wr_seen; s_bst = bst_cnt; s_take = take_cnt;
        s_rmis = rd_mis; s_wmis = wr_mis; s_nop = nop_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        acc = cyc;
        exp_pins = wr ? 4'b0100 : 4'b0101;
        check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == exp_pins, "R2 command pins",
              int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), int'(exp_pins));
        check(cmd_addr == a, "R2 address", int'(cmd_addr), int'(a));
        for (int k = 1; k <= 40; k++) begin
            stop_req = (k == stop_at);
            @(negedge clk);
            if (k == stop_at && stop_at < bl) begin
                check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b0110, "R6 stop pins",
                      int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), 6);
                check(dq_oe == 1'b0, "R7 bus released on stop", int'(dq_oe), 0);
            end
        end
        stop_req = 1'b0;
        #1;
        exp_beats = (stop_at >= 1 && stop_at < bl) ? stop_at : bl;
        exp_bst   = (stop_at >= 1 && stop_at < bl) ? 1 : 0;
        if (stop_at >= bl)
            check(bst_cnt - s_bst == 0, "R8 late stop makes no command", bst_cnt - s_bst, 0);
        else
            check(bst_cnt - s_bst == exp_bst, "R6 stop count", bst_cnt - s_bst, exp_bst);
        check(nop_cnt - s_nop == 0, "R3 no NOP fill", nop_cnt - s_nop, 0);
        if (wr) begin
            check(wr_seen - s_wr == exp_beats, "R7 R11 write beats", wr_seen - s_wr, exp_beats);
            check(take_cnt - s_take == exp_beats, "R10 take count", take_cnt - s_take, exp_beats);
            check(wr_mis - s_wmis == 0, "R10 write data order", wr_mis - s_wmis, 0);
            check(rd_seen - s_rd == 0, "R7 no read data on write", rd_seen - s_rd, 0);
        end else begin
            check(rd_seen - s_rd == exp_beats, "R4 R6 R11 read beats", rd_seen - s_rd, exp_beats);
            check(rd_mis - s_rmis == 0, "R4 read data order", rd_mis - s_rmis, 0);
            check(rise_cyc - acc == (cl3 ? 4 : 3), "R5 first word latency",
                  rise_cyc - acc, cl3 ? 4 : 3);
            check(wr_seen - s_wr == 0, "R4 no bus drive on read", wr_seen - s_wr, 0);
        end
    endtask

    // R9: requests while busy are not taken
    task automatic run_busy_ignore();
        int s_rd, s_take;
        @(negedge clk); #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        cas_lat_3 = 1'b1; burst_len = 4'd4; dev_bl = 4;
        req_write = 1'b0; req_addr = 13'h0033; req_valid = 1'b1;
        s_rd = rd_seen; s_take = take_cnt;
        @(negedge clk);
        req_write = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R9 ready low while busy", int'(req_ready), 0);
            check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} != 4'b0100, "R9 no write while busy",
                  int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), 15);
        end
        req_valid = 1'b0;
        req_write = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        check(rd_seen - s_rd == 4, "R9 read completes", rd_seen - s_rd, 4);
        check(take_cnt - s_take == 0, "R9 busy write not taken", take_cnt - s_take, 0);
        check(req_ready == 1'b1, "R9 ready after drain", int'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_reset();
        for (int s = 0; s <= 5; s++) run_burst(1'b0, 1'b0, 4, s);
        for (int s = 0; s <= 5; s++) run_burst(1'b0, 1'b1, 4, s);
        for (int s = 0; s <= 5; s++) run_burst(1'b1, 1'b0, 4, s);
        run_burst(1'b1, 1'b1, 4, 2);
        run_burst(1'b0, 1'b1, 1, 0);
        run_burst(1'b1, 1'b0, 1, 1);
        run_burst(1'b0, 1'b1, 8, 5);
        run_burst(1'b1, 1'b1, 8, 0);
        run_busy_ignore();
        run_burst(1'b0, 1'b0, 4, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule